// File: doc/BRIEF.md
# Programming Command Scan Register

This block is a test-data register for a boundary-scan port. It passes command words to an on-chip memory programmer and reads results back. A TAP controller drives it with state strobes that are sampled on TCK: capture, shift, update and run-test/idle. It is active only when the instruction register holds the programming-command code.

In the capture state the register loads the result word that the memory programmer returned for the command applied before. During shifting, that result leaves on TDO least significant bit first while the next command enters from TDI. On update, the shifted word is latched onto the command outputs that feed the programmer. When the TAP controller enters run-test/idle, the block gives the programmer a single execute pulse.

The TAP state machine, the instruction register and the memory array sit outside the block.

Top module: `progcmd_dr`

## Requirements
- R1: The register is selected only while the 4-bit instruction code input equals 5. With any other code, the capture, shift, update and idle strobes have no effect: cmd_o keeps its value, exec_o stays low and tdo reads 0.
- R2: On a rising TCK edge with capture asserted while selected, the 15-bit register loads result_i.
- R3: On a rising TCK edge with shift asserted while selected, bit 0 leaves the register, the other bits move one place toward bit 0, and tdi enters bit 14. On each falling TCK edge, tdo takes bit 0 of the register while selected, and 0 otherwise.
- R4: A capture followed by 15 shifts presents the captured result on tdo least significant bit first. The 15 tdi bits shifted in, first bit to bit 0, form the new command word.
- R5: On a rising edge with update asserted while selected, cmd_o takes the register contents. At every other edge cmd_o holds its value, including while deselected.
- R6: exec_o is high for exactly one TCK cycle after a rising edge that sees the idle strobe asserted while selected, when the idle strobe was low at the edge before.
- R7: No execute pulse is issued while the register is deselected.
- R8: A synchronous active-high reset clears cmd_o, exec_o, tdo and the register. An idle strobe that is already high at reset release produces no pulse until it has gone low and risen again.
- R9: result_i is sampled only at capture. Changes on it during shifting do not alter the bits that appear on tdo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high TAP reset |
| ir_code | input | 4 | Current instruction code |
| st_capture | input | 1 | Capture-DR state strobe |
| st_shift | input | 1 | Shift-DR state strobe |
| st_update | input | 1 | Update-DR state strobe |
| st_idle | input | 1 | Run-test/idle state strobe |
| tdi | input | 1 | Serial data in |
| result_i | input | 15 | Result word returned by the memory programmer |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| cmd_o | output | 15 | Applied command word |
| exec_o | output | 1 | One-cycle execute pulse |

## Verification
The assertions check on every rising edge the following: the capture load, the one-place shift with tdi entering at the top, the update transfer, and that cmd_o holds at all other edges. They also check that the execute pulse never lasts two cycles and never follows a deselected edge. Some behaviour spans many cycles and only the bench scenarios can show it. This covers the whole round trip, in which the captured result emerges bit by bit on the falling-edge tdo while a command goes in. It also covers insensitivity to result_i changing mid-shift, the suppressed pulse after reset release, and the inert register under a foreign instruction code. A queue-based reference model is compared against all three outputs every cycle.

// File: rtl/progcmd_pkg.sv
`timescale 1ns/1ps
package progcmd_pkg;
  localparam int CMD_W_DEF    = 15;
  localparam int IR_W_DEF     = 4;
  localparam int SEL_CODE_DEF = 5;

  typedef struct packed {
    logic cap;
    logic shf;
    logic upd;
    logic idle;
  } tap_strb_t;
endpackage

// File: rtl/progcmd_shift.sv
`timescale 1ns/1ps
module progcmd_shift #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         cap,
  input  logic         shf,
  input  logic         tdi,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] shreg_o,
  output logic         tdo_o
);
  logic [W-1:0] shreg;
  logic         tdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (sel && cap) begin
      shreg <= load_val;
    end else if (sel && shf) begin
      shreg <= {tdi, shreg[W-1:1]};
    end
  end

  // output stage on the falling edge so the receiver samples a settled bit
  always_ff @(negedge clk) begin
    if (rst) tdo_q <= 1'b0;
    else     tdo_q <= sel ? shreg[0] : 1'b0;
  end

  assign shreg_o = shreg;
  assign tdo_o   = tdo_q;

  // R2
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && cap) |=> (shreg == $past(load_val)));
  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && shf && !cap) |=> (shreg[W-2:0] == $past(shreg[W-1:1]) && shreg[W-1] == $past(tdi)));
  // R1
  desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(shreg));
endmodule

// File: rtl/progcmd_apply.sv
`timescale 1ns/1ps
module progcmd_apply #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         upd,
  input  logic [W-1:0] shreg_i,
  output logic [W-1:0] cmd_o
);
  logic [W-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (rst)              cmd_q <= '0;
    else if (sel && upd)  cmd_q <= shreg_i;
  end

  assign cmd_o = cmd_q;

  // R5
  apply_take_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && upd) |=> (cmd_o == $past(shreg_i)));
  // R5
  apply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel && upd) |=> $stable(cmd_o));
endmodule

// File: rtl/progcmd_exec.sv
`timescale 1ns/1ps
module progcmd_exec (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic idle,
  output logic exec_o
);
  logic idle_prev;
  logic ex_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_prev <= 1'b1;
      ex_q      <= 1'b0;
    end else begin
      idle_prev <= idle;
      ex_q      <= sel && idle && !idle_prev;
    end
  end

  assign exec_o = ex_q;

  // R6
  exec_single_chk: assert property (@(posedge clk) disable iff (rst)
    exec_o |=> !exec_o);
  // R6
  exec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && idle && exec_o) |=> !exec_o);
  // R7
  exec_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !exec_o);
endmodule

// File: rtl/progcmd_dr.sv
`timescale 1ns/1ps
module progcmd_dr
  import progcmd_pkg::*;
#(
  parameter int CMD_W    = CMD_W_DEF,
  parameter int IR_W     = IR_W_DEF,
  parameter int SEL_CODE = SEL_CODE_DEF
) (
  input  logic             tck,
  input  logic             tap_rst,
  input  logic [IR_W-1:0]  ir_code,
  input  logic             st_capture,
  input  logic             st_shift,
  input  logic             st_update,
  input  logic             st_idle,
  input  logic             tdi,
  input  logic [CMD_W-1:0] result_i,
  output logic             tdo,
  output logic [CMD_W-1:0] cmd_o,
  output logic             exec_o
);
  localparam logic [IR_W-1:0] CODE = IR_W'(SEL_CODE);

  logic             sel;
  tap_strb_t        strb;
  logic [CMD_W-1:0] shreg;

  assign sel  = (ir_code == CODE);
  assign strb = '{cap: st_capture, shf: st_shift, upd: st_update, idle: st_idle};

  progcmd_shift #(.W(CMD_W)) u_shift (
    .clk      (tck),
    .rst      (tap_rst),
    .sel      (sel),
    .cap      (strb.cap),
    .shf      (strb.shf),
    .tdi      (tdi),
    .load_val (result_i),
    .shreg_o  (shreg),
    .tdo_o    (tdo)
  );

  progcmd_apply #(.W(CMD_W)) u_apply (
    .clk     (tck),
    .rst     (tap_rst),
    .sel     (sel),
    .upd     (strb.upd),
    .shreg_i (shreg),
    .cmd_o   (cmd_o)
  );

  progcmd_exec u_exec (
    .clk    (tck),
    .rst    (tap_rst),
    .sel    (sel),
    .idle   (strb.idle),
    .exec_o (exec_o)
  );

  // R8
  reset_clear_chk: assert property (@(posedge tck)
    $past(tap_rst) |-> (cmd_o == '0 && !exec_o));
endmodule

// File: tb/tb_progcmd_dr.sv
`timescale 1ns/1ps
module tb_progcmd_dr;
  localparam int W = 15;

  logic         tck = 1'b0;
  logic         tap_rst = 1'b1;
  logic [3:0]   ir_code = 4'h0;
  logic         st_capture = 1'b0, st_shift = 1'b0, st_update = 1'b0, st_idle = 1'b0;
  logic         tdi = 1'b0;
  logic [W-1:0] result_i = '0;
  logic         tdo;
  logic [W-1:0] cmd_o;
  logic         exec_o;

  int n_run = 0;
  int n_fail = 0;
  int ex_cnt = 0;
  logic got_tdo;

  // reference model state
  logic         mq[$];
  logic [W-1:0] m_cmd = '0;
  logic         m_ex = 1'b0;
  logic         m_prev = 1'b1;

  always #4 tck = ~tck;

  progcmd_dr dut (
    .tck(tck), .tap_rst(tap_rst), .ir_code(ir_code),
    .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update), .st_idle(st_idle),
    .tdi(tdi), .result_i(result_i), .tdo(tdo), .cmd_o(cmd_o), .exec_o(exec_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [W-1:0] mq_pack();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = mq[i];
    return v;
  endfunction

  task automatic model_clear();
    mq.delete();
    for (int i = 0; i < W; i++) mq.push_back(1'b0);
  endtask

  // one TCK cycle, entered and left 1 ns after a rising edge
  task automatic cyc(input logic c, input logic s, input logic u, input logic i, input logic d);
    logic sel_now;
    logic exp_tdo;
    st_capture = c; st_shift = s; st_update = u; st_idle = i; tdi = d;
    sel_now = (ir_code == 4'h5);
    exp_tdo = tap_rst ? 1'b0 : (sel_now ? mq[0] : 1'b0);
    #4;
    got_tdo = tdo;
    chk("R3", "tdo", {31'd0, tdo}, {31'd0, exp_tdo});
    @(posedge tck);
    if (tap_rst) begin
      model_clear(); m_cmd = '0; m_ex = 1'b0; m_prev = 1'b1;
    end else begin
      m_ex = sel_now && i && !m_prev;
      m_prev = i;
      if (sel_now && u) m_cmd = mq_pack();
      if (sel_now && c) begin
        mq.delete();
        for (int k = 0; k < W; k++) mq.push_back(result_i[k]);
      end else if (sel_now && s) begin
        void'(mq.pop_front());
        mq.push_back(d);
      end
    end
    #1;
    chk("R5", "cmd_o", {17'd0, cmd_o}, {17'd0, m_cmd});
    chk("R6", "exec_o", {31'd0, exec_o}, {31'd0, m_ex});
    if (exec_o) ex_cnt++;
  endtask

  // capture, shift a command in, update; returns bits seen on tdo
  task automatic round_trip(input logic [W-1:0] res, input logic [W-1:0] cmd,
                            input logic [W-1:0] res_late, output logic [W-1:0] seen);
    result_i = res;
    cyc(1, 0, 0, 0, 0);
    result_i = res_late;
    for (int k = 0; k < W; k++) begin
      cyc(0, 1, 0, 0, cmd[k]);
      seen[k] = got_tdo;
    end
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] seen;
    model_clear();
    @(posedge tck); #1;
    // R8 reset, idle already high at release
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    ir_code = 4'h5;
    cyc(0, 0, 0, 1, 0);
    tap_rst = 1'b0;
    ex_cnt = 0;
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R8", "cmd_o after reset", {17'd0, cmd_o}, 32'd0);
    chk("R8", "tdo after reset", {31'd0, tdo}, 32'd0);
    chk("R8", "no pulse from idle held through reset", ex_cnt, 0);

    // R6 idle left and re-entered
    cyc(0, 0, 0, 0, 0);
    ex_cnt = 0;
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R6", "pulse count on idle entry", ex_cnt, 1);

    // R2 R4 round trip
    round_trip(15'h1234, 15'h2A5C, 15'h1234, seen);
    chk("R2", "captured result on tdo", {17'd0, seen}, {17'd0, 15'h1234});
    chk("R4", "command after update", {17'd0, cmd_o}, {17'd0, 15'h2A5C});
    ex_cnt = 0;
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R6", "single execute after apply", ex_cnt, 1);
    cyc(0, 0, 0, 0, 0);

    // R9 result changes mid-shift
    round_trip(15'h7FFF, 15'h0001, 15'h0000, seen);
    chk("R9", "late result change ignored", {17'd0, seen}, {17'd0, 15'h7FFF});
    chk("R4", "second command", {17'd0, cmd_o}, {17'd0, 15'h0001});
    round_trip(15'h4001, 15'h5555, 15'h3C3C, seen);
    chk("R4", "alternating command", {17'd0, cmd_o}, {17'd0, 15'h5555});
    chk("R2", "edge-bit result", {17'd0, seen}, {17'd0, 15'h4001});

    // R1 R7 foreign instruction code
    ir_code = 4'h3;
    ex_cnt = 0;
    round_trip(15'h0F0F, 15'h1111, 15'h0F0F, seen);
    chk("R1", "tdo while deselected", {17'd0, seen}, 32'd0);
    chk("R1", "cmd_o while deselected", {17'd0, cmd_o}, {17'd0, 15'h5555});
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R7", "no execute while deselected", ex_cnt, 0);
    cyc(0, 0, 0, 0, 0);

    // R5 hold with register reselected but no update
    ir_code = 4'h5;
    result_i = 15'h0AAA;
    cyc(1, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 1'b1);
    cyc(0, 0, 0, 0, 0);
    chk("R5", "cmd_o holds without update", {17'd0, cmd_o}, {17'd0, 15'h5555});

    // R8 reset in mid-operation
    tap_rst = 1'b1;
    cyc(0, 0, 0, 0, 0);
    tap_rst = 1'b0;
    cyc(0, 0, 0, 0, 0);
    chk("R8", "cmd_o cleared by reset", {17'd0, cmd_o}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule